// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a line that rests at logic 1. A single-cycle write strobe captures the character, and the block then reports busy until the whole frame has left the line. Bit timing comes from outside: a one-cycle bit-rate tick, usually from a shared rate generator, marks the start of each bit period. The first tick after the load opens the start bit, so every bit, the start bit included, lasts one full tick interval.

The frame format is set by static configuration inputs. They choose seven or eight data bits, whether a parity bit is added and whether that parity is even or odd, and whether one or two stop bits close the frame. A run enable turns the whole transmitter off. While it is low, the line is held high, busy is held low, and all other inputs are ignored. Dropping it in the middle of a frame abandons that frame.

Top module: `uart_serializer`

## Requirements
- R1: A write strobe taken while idle and enabled loads the character. The line stays at 1 until the first bit tick that comes after the load cycle. A tick in the same cycle as the strobe does not count as that first tick.
- R2: After each tick, the line shows the next frame bit and holds it until the following tick. The frame is sent as: a start bit of 0, then the data bits with bit 0 first, then the parity bit if enabled, then the stop bits.
- R3: Busy is 1 from the cycle after the load. It returns to 0 in the cycle after the tick that ends the last stop bit's period, and the line is 1 at that point.
- R4: A write strobe while busy is ignored. The frame in progress is sent unchanged.
- R5: With `data_wide` = 0, seven data bits (bits 6:0) are sent and bit 7 of the data input has no effect on the frame. With `data_wide` = 1, all eight bits are sent.
- R6: With `par_on` = 1, one parity bit follows the data. With `par_odd` = 0, the count of ones in the sent data plus parity is even. With `par_odd` = 1, that count is odd. With `par_on` = 0, no parity bit is sent.
- R7: With `stop_two` = 0, one stop bit of value 1 is sent. With `stop_two` = 1, two stop bits of value 1 are sent.
- R8: After reset, the line is 1 and busy is 0. Whenever busy is 0, the line is 1.
- R9: While `run_en` is 0, the line is 1, busy is 0, and strobes and ticks have no effect. Dropping `run_en` in the middle of a frame abandons the frame, so the block is idle when `run_en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Transmitter enable |
| data_wide | input | 1 | 1: eight data bits, 0: seven data bits |
| par_on | input | 1 | Adds a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop_two | input | 1 | 1: two stop bits, 0: one stop bit |
| bit_tick | input | 1 | One-cycle bit-rate pulse |
| wr_strobe | input | 1 | One-cycle load request |
| wr_data | input | 8 | Character to send |
| tx_line | output | 1 | Serial output, rests at 1 |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that the format inputs stay constant while a frame is in flight, and that `bit_tick` and `wr_strobe` are clean one-cycle pulses in the clock domain. The stimulus changes the configuration only between frames, while busy is low. It drives every strobe and tick for exactly one cycle, at the falling clock edge. Strobes issued while busy are deliberate, to test that they are ignored. Tick spacing is randomised between one and several cycles, which tests that the line holds its value between ticks.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } txs_state_e;

    typedef struct packed {
        logic data_wide;
        logic par_on;
        logic par_odd;
        logic stop_two;
    } txs_fmt_t;

endpackage

// File: rtl/txs_frame_build.sv
module txs_frame_build
    import txs_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  txs_fmt_t            fmt,
    input  logic [DATA_W-1:0]   data,
    output logic [FRAME_W-1:0]  frame,
    output logic [CNT_W-1:0]    nbits
);

    localparam int NARROW_W = DATA_W - 1;

    logic [DATA_W-1:0] mask_d;
    logic [DATA_W-1:0] used_d;
    logic [CNT_W-1:0]  dcount_d;
    logic              parity_d;
    logic [CNT_W-1:0]  par_pos_d;

    always_comb begin
        mask_d           = '1;
        mask_d[DATA_W-1] = fmt.data_wide;
        used_d           = data & mask_d;
        dcount_d         = fmt.data_wide ? CNT_W'(DATA_W) : CNT_W'(NARROW_W);
        parity_d         = (^used_d) ^ fmt.par_odd;
        par_pos_d        = dcount_d + CNT_W'(1);

        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < dcount_d) begin
                frame[1 + i] = used_d[i];
            end
        end
        if (fmt.par_on) begin
            frame[par_pos_d] = parity_d;
        end

        nbits = dcount_d + CNT_W'(2) + CNT_W'(fmt.par_on) + CNT_W'(fmt.stop_two);
    end

endmodule

// File: rtl/txs_shift_ctl.sv
module txs_shift_ctl
    import txs_pkg::*;
#(
    parameter int FRAME_W = 12,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               bit_tick,
    input  logic               wr_strobe,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [CNT_W-1:0]   nbits_in,
    output logic               tx_line,
    output logic               busy
);

    typedef struct packed {
        txs_state_e         state;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   cnt;
        logic               line;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (!run_en) begin
            ctl_d.state = ST_IDLE;
            ctl_d.line  = 1'b1;
        end else begin
            case (ctl_q.state)
                ST_IDLE: begin
                    ctl_d.line = 1'b1;
                    if (wr_strobe) begin
                        ctl_d.frame = frame_in;
                        ctl_d.cnt   = nbits_in;
                        ctl_d.state = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (bit_tick) begin
                        ctl_d.line  = ctl_q.frame[0];
                        ctl_d.frame = {1'b1, ctl_q.frame[FRAME_W-1:1]};
                        ctl_d.cnt   = ctl_q.cnt - CNT_W'(1);
                        ctl_d.state = ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (bit_tick) begin
                        if (ctl_q.cnt == '0) begin
                            ctl_d.line  = 1'b1;
                            ctl_d.state = ST_IDLE;
                        end else begin
                            ctl_d.line  = ctl_q.frame[0];
                            ctl_d.frame = {1'b1, ctl_q.frame[FRAME_W-1:1]};
                            ctl_d.cnt   = ctl_q.cnt - CNT_W'(1);
                        end
                    end
                end
                default: begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.line  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.frame <= '1;
            ctl_q.cnt   <= '0;
            ctl_q.line  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_line = ctl_q.line | ~run_en;
    assign busy    = run_en & (ctl_q.state != ST_IDLE);

    // R1: the line rests high while waiting for the first tick
    p_armed_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_ARMED) |-> tx_line);

    // R2: without a tick the line holds its value
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !bit_tick) |=> ($stable(tx_line) || !run_en));

    // R3: a load raises busy in the next cycle
    p_load_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && wr_strobe && !busy) |=> (busy || !run_en));

    // R4: a strobe while busy leaves the bit count untouched
    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_strobe && !bit_tick) |=> $stable(ctl_q.cnt));

    // R8: the line is high whenever no frame is in flight
    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    // R9: disabling returns the controller to idle
    p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (ctl_q.state == ST_IDLE));

endmodule

// File: rtl/uart_serializer.sv
module uart_serializer
    import txs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              data_wide,
    input  logic              par_on,
    input  logic              par_odd,
    input  logic              stop_two,
    input  logic              bit_tick,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_line,
    output logic              busy
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    txs_fmt_t           fmt;
    logic [FRAME_W-1:0] frame_w;
    logic [CNT_W-1:0]   nbits_w;

    assign fmt = '{data_wide: data_wide, par_on: par_on,
                   par_odd: par_odd, stop_two: stop_two};

    txs_frame_build #(
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_build (
        .fmt  (fmt),
        .data (wr_data),
        .frame(frame_w),
        .nbits(nbits_w)
    );

    txs_shift_ctl #(
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .bit_tick (bit_tick),
        .wr_strobe(wr_strobe),
        .frame_in (frame_w),
        .nbits_in (nbits_w),
        .tx_line  (tx_line),
        .busy     (busy)
    );

endmodule

// File: tb/uart_serializer_test.sv
`timescale 1ns/1ps
module uart_serializer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b1;
    logic       data_wide = 1'b1;
    logic       par_on = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop_two = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_line;
    logic       busy;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    uart_serializer uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .data_wide(data_wide),
        .par_on(par_on), .par_odd(par_odd), .stop_two(stop_two),
        .bit_tick(bit_tick), .wr_strobe(wr_strobe), .wr_data(wr_data),
        .tx_line(tx_line), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected frame, bit i sent i-th; returns the bit count through nb
    function automatic logic [11:0] ref_frame(input logic [7:0] d, input bit w8,
                                              input bit pe, input bit po,
                                              input bit s2, output int nb);
        logic [11:0] f;
        int k;
        int ones;
        f = '1;
        k = 0;
        ones = 0;
        f[k] = 1'b0; k++;
        for (int i = 0; i < (w8 ? 8 : 7); i++) begin
            f[k] = d[i]; ones += d[i]; k++;
        end
        if (pe) begin
            f[k] = (po ? (ones % 2 == 0) : (ones % 2 == 1)); k++;
        end
        k += s2 ? 2 : 1;
        nb = k;
        return f;
    endfunction

    task automatic tick_pulse();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input int gap,
                              input bit poke, input bit tick_with_load);
        logic [11:0] exp_f;
        logic [11:0] got;
        int nb;
        bit busy_ok;
        exp_f = ref_frame(d, data_wide, par_on, par_odd, stop_two, nb);
        got = '1;
        busy_ok = 1'b1;
        @(negedge clk);
        wr_data = d; wr_strobe = 1'b1; bit_tick = tick_with_load;
        @(negedge clk);
        wr_strobe = 1'b0; bit_tick = 1'b0;
        check(busy == 1'b1, "R3 busy after load", busy, 1);
        check(tx_line == 1'b1, "R1 line high before first tick", tx_line, 1);
        repeat (gap) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            tick_pulse();
            got[i] = tx_line;
            if (busy !== 1'b1) busy_ok = 1'b0;
            if (poke && i == 2) begin
                wr_data = ~d; wr_strobe = 1'b1;
                @(negedge clk) wr_strobe = 1'b0;
            end
            repeat (gap) begin
                @(negedge clk);
                if (tx_line !== got[i]) busy_ok = 1'b0;
            end
        end
        check(got == exp_f, "R2 R4 R5 R6 R7 frame bits", got, exp_f);
        check(busy_ok, "R2 R3 busy and line hold during frame", busy_ok, 1);
        tick_pulse();
        check(busy == 1'b0 && tx_line == 1'b1, "R3 busy drops after last stop",
              {busy, tx_line}, 2'b01);
    endtask

    initial begin
        #1500000;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        logic [11:0] fa, fb;
        int na, nb;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && tx_line == 1'b1, "R8 reset state", {busy, tx_line}, 2'b01);

        // R5: bit 7 is irrelevant in seven-bit mode
        fa = ref_frame(8'h55, 1'b0, 1'b1, 1'b0, 1'b0, na);
        fb = ref_frame(8'hD5, 1'b0, 1'b1, 1'b0, 1'b0, nb);
        check(fa == fb && na == nb, "R5 reference ignores bit 7", fb, fa);

        // every format combination, directed
        for (int c = 0; c < 16; c++) begin
            data_wide = c[0]; par_on = c[1]; par_odd = c[2]; stop_two = c[3];
            send_frame(8'hA5, 0, 1'b0, 1'b0);
            send_frame(8'hD3, 1, 1'b0, 1'b0);
        end

        // R1: tick in the load cycle does not start the frame
        data_wide = 1'b1; par_on = 1'b1; par_odd = 1'b1; stop_two = 1'b0;
        send_frame(8'h00, 2, 1'b0, 1'b1);

        // R4: strobe while busy
        send_frame(8'h3C, 1, 1'b1, 1'b0);

        // random frames
        for (int n = 0; n < 60; n++) begin
            logic [3:0] cfg;
            cfg = 4'($urandom);
            data_wide = cfg[0]; par_on = cfg[1]; par_odd = cfg[2]; stop_two = cfg[3];
            send_frame(8'($urandom), int'($urandom_range(0, 3)),
                       bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        end

        // R9: disabled transmitter ignores strobe and tick
        @(negedge clk);
        run_en = 1'b0; wr_data = 8'h00; wr_strobe = 1'b1; bit_tick = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0; bit_tick = 1'b0;
        check(busy == 1'b0 && tx_line == 1'b1, "R9 disabled outputs inactive",
              {busy, tx_line}, 2'b01);
        tick_pulse();
        run_en = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R9 strobe while disabled ignored", busy, 0);

        // R9: abandon mid-frame
        @(negedge clk);
        wr_data = 8'h00; wr_strobe = 1'b1;
        @(negedge clk) wr_strobe = 1'b0;
        tick_pulse();
        tick_pulse();
        check(tx_line == 1'b0, "R2 data zero on line", tx_line, 0);
        run_en = 1'b0;
        #1;
        check(busy == 1'b0 && tx_line == 1'b1, "R9 drop forces inactive",
              {busy, tx_line}, 2'b01);
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && tx_line == 1'b1, "R9 frame abandoned",
              {busy, tx_line}, 2'b01);
        tick_pulse();
        check(busy == 1'b0 && tx_line == 1'b1, "R8 idle after abandon",
              {busy, tx_line}, 2'b01);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule